// File: doc/BRIEF.md
# Row-scan coded-exposure sequencer

This block sequences a pixel array that has a one-bit exposure memory inside every pixel. When a unit frame starts it visits the rows in ascending order. For each row it asks the pattern generator for two vectors. The exposure vector says which pixels of the row end an exposure window in this frame. The enable vector says which of those pixels go to the column converters. The row procedure then runs five steps, each with its own length. First the new exposure bits go onto the bit lines and into the pixel memories. Then the row is selected and the charge is transferred. The enabled columns are converted. Last, a reset strobe clears only the pixels whose memory bit is set.

A pixel whose bit is clear stays isolated: it keeps integrating across unit frames and is neither read nor cleared. The value read from a pixel is therefore the sum of the scene over the frames since its last reset, which is one term of a coded image. A behavioural pixel array sits inside the block and is driven by the same strobes the real array would see. It integrates a per-pixel scene value at every accepted frame start, so the coded accumulation can be checked at the read port.

Top module: `cexp_row_sequencer`

## Requirements
- R1: After reset all word, bit, select, transfer, reset and conversion lines are low, `row_req` and `rd_valid` are low, and `rd_data` is zero.
- R2: A `frame_start` pulse seen while the block is idle starts one scan that requests rows 0 to NUM_ROWS-1 in ascending order, each exactly once. A `frame_start` pulse during a scan is ignored: it adds no rows and no integration.
- R3: Each row takes 1 + W + S + X + C + Z cycles. W is max(t_write,2); S, X, C and Z are t_select, t_xfer, t_conv and t_reset with 0 treated as 1. The timing inputs are captured at the accepted `frame_start`.
- R4: During the write step, `bit_ln` carries the row's exposure bits and `bit_n` carries their complement. Bit c of each vector is column c. The row's `word_ln` bit (bit r is row r) pulses only in the last write cycle, after the bit lines have held steady for at least one cycle. While it pulses, no row is selected and neither transfer nor reset is active.
- R5: `rsel` is one-hot on the current row from the select step through the reset step, and zero otherwise. `xfer_ln` is high only during the transfer step.
- R6: During the conversion step, `conv_en` equals the bitwise AND of the row's exposure and enable bits. It is zero at all other times.
- R7: One cycle after the conversion step, `rd_valid` pulses for one cycle if any `conv_en` bit was set, and stays low otherwise. With the pulse, `rd_row` gives the row. `rd_data` bits [c*ACC_W +: ACC_W] give column c's converted value, and that field is zero for columns that were not converted.
- R8: `rst_ln` is high during the reset step. It clears only the pixels of the selected row whose memory bit is 1.
- R9: A pixel whose memory bit is 0 is not cleared and not read, and it keeps its accumulated value into later frames.
- R10: At each accepted `frame_start`, every pixel adds its scene value (`scene` bits [(r*NUM_COLS+c)*SCN_W +: SCN_W] for row r, column c) and saturates at 2^ACC_W-1.
- R11: A converted value equals the sum of that pixel's scene values over all accepted frames since its last reset, including the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Unit-frame start pulse |
| t_write | input | CNT_W | Write step length in cycles |
| t_select | input | CNT_W | Select step length |
| t_xfer | input | CNT_W | Transfer step length |
| t_conv | input | CNT_W | Conversion step length |
| t_reset | input | CNT_W | Reset step length |
| row_req | output | 1 | Row vector request, one cycle per row |
| row_idx | output | ROW_W | Row currently being sequenced |
| exp_vec | input | NUM_COLS | Exposure bits for row_idx, sampled while row_req is high |
| en_vec | input | NUM_COLS | Conversion enable bits for row_idx, sampled with exp_vec |
| scene | input | NUM_ROWS*NUM_COLS*SCN_W | Per-pixel scene value for the pixel model |
| word_ln | output | NUM_ROWS | Per-row memory write strobe |
| bit_ln | output | NUM_COLS | Bit-line data |
| bit_n | output | NUM_COLS | Complement bit-line data |
| rsel | output | NUM_ROWS | Row select |
| xfer_ln | output | 1 | Charge transfer strobe |
| rst_ln | output | 1 | Pixel reset strobe, gated in-pixel by the memory bit |
| conv_en | output | NUM_COLS | Column converter enables |
| rd_valid | output | 1 | Row readout valid |
| rd_row | output | ROW_W | Row of the readout |
| rd_data | output | NUM_COLS*ACC_W | Converted column values |

## Verification
The bound checker watches the strobe discipline on every cycle. It checks that the bit lines are steady and complementary under a word pulse, and that word, transfer and reset never overlap. It also checks that the row select is one-hot whenever transfer, conversion or reset is active, and that the readout pulse lasts one cycle and always follows a conversion. Other behaviours only show up across whole frames, so the scoreboard bench covers them: the row order and step lengths with the zero-length floors, and the value each pixel accumulates across isolated frames. It also covers the clamp at full scale and that a frame pulse arriving mid-scan is ignored.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_WRITE,
      ST_SELECT,
      ST_XFER,
      ST_CONV,
      ST_RESET
   } seq_state_t;
endpackage

// File: rtl/cexp_step_timer.sv
module cexp_step_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len_m1,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= len_m1;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/cexp_row_fsm.sv
module cexp_row_fsm
   import cexp_pkg::*;
#(
   parameter int NUM_ROWS = 4,
   parameter int CNT_W    = 4,
   parameter int ROW_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic [CNT_W-1:0] t_write,
   input  logic [CNT_W-1:0] t_select,
   input  logic [CNT_W-1:0] t_xfer,
   input  logic [CNT_W-1:0] t_conv,
   input  logic [CNT_W-1:0] t_reset,
   output seq_state_t       state_o,
   output logic [ROW_W-1:0] row_o,
   output logic             step_last,
   output logic             integ
);
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);
   localparam logic [CNT_W-1:0] FLOOR_WR = CNT_W'(2);
   localparam logic [CNT_W-1:0] FLOOR_1  = CNT_W'(1);

   function automatic logic [CNT_W-1:0] span_m1(input logic [CNT_W-1:0] t,
                                                input logic [CNT_W-1:0] floor_v);
      return (t < floor_v) ? floor_v - 1'b1 : t - 1'b1;
   endfunction

   seq_state_t       state_q, state_d;
   logic [ROW_W-1:0] row_q;
   logic [CNT_W-1:0] tw_q, ts_q, tx_q, tc_q, tr_q;
   logic             t_load;
   logic [CNT_W-1:0] t_len;
   logic             accept;

   assign accept = (state_q == ST_IDLE) && frame_start;

   cexp_step_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (t_load),
      .len_m1 (t_len),
      .last   (step_last)
   );

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_len   = '0;
      unique case (state_q)
         ST_IDLE:   if (frame_start) state_d = ST_LOAD;
         ST_LOAD: begin
            state_d = ST_WRITE;
            t_load  = 1'b1;
            t_len   = span_m1(tw_q, FLOOR_WR);
         end
         ST_WRITE: if (step_last) begin
            state_d = ST_SELECT;
            t_load  = 1'b1;
            t_len   = span_m1(ts_q, FLOOR_1);
         end
         ST_SELECT: if (step_last) begin
            state_d = ST_XFER;
            t_load  = 1'b1;
            t_len   = span_m1(tx_q, FLOOR_1);
         end
         ST_XFER: if (step_last) begin
            state_d = ST_CONV;
            t_load  = 1'b1;
            t_len   = span_m1(tc_q, FLOOR_1);
         end
         ST_CONV: if (step_last) begin
            state_d = ST_RESET;
            t_load  = 1'b1;
            t_len   = span_m1(tr_q, FLOOR_1);
         end
         ST_RESET: if (step_last) begin
            state_d = (row_q == LAST_ROW) ? ST_IDLE : ST_LOAD;
         end
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         tw_q    <= '0;
         ts_q    <= '0;
         tx_q    <= '0;
         tc_q    <= '0;
         tr_q    <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            row_q <= '0;
            tw_q  <= t_write;
            ts_q  <= t_select;
            tx_q  <= t_xfer;
            tc_q  <= t_conv;
            tr_q  <= t_reset;
         end else if (state_q == ST_RESET && step_last && row_q != LAST_ROW) begin
            row_q <= row_q + 1'b1;
         end
      end
   end

   assign state_o = state_q;
   assign row_o   = row_q;
   assign integ   = accept;
endmodule

// File: rtl/cexp_col_bank.sv
module cexp_col_bank #(
   parameter int NUM_COLS = 8,
   parameter int ACC_W    = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap,
   input  logic [NUM_COLS-1:0]       exp_vec,
   input  logic [NUM_COLS-1:0]       en_vec,
   input  logic                      in_write,
   input  logic                      in_conv,
   input  logic                      conv_done,
   input  logic [NUM_COLS*ACC_W-1:0] col_level,
   output logic [NUM_COLS-1:0]       bit_ln,
   output logic [NUM_COLS-1:0]       bit_n,
   output logic [NUM_COLS-1:0]       conv_en,
   output logic                      rd_valid,
   output logic [NUM_COLS*ACC_W-1:0] rd_data
);
   logic [NUM_COLS-1:0] exp_q, en_q;

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      logic [ACC_W-1:0] out_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            exp_q[c] <= 1'b0;
            en_q[c]  <= 1'b0;
            out_q    <= '0;
         end else begin
            if (cap) begin
               exp_q[c] <= exp_vec[c];
               en_q[c]  <= en_vec[c];
            end
            if (conv_done)
               out_q <= conv_en[c] ? col_level[c*ACC_W +: ACC_W] : '0;
         end
      end

      assign bit_ln[c]  = in_write & exp_q[c];
      assign bit_n[c]   = in_write & ~exp_q[c];
      assign conv_en[c] = in_conv & exp_q[c] & en_q[c];
      assign rd_data[c*ACC_W +: ACC_W] = out_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= conv_done & (|conv_en);
   end
endmodule

// File: rtl/cexp_pixel_model.sv
module cexp_pixel_model #(
   parameter int NUM_ROWS = 4,
   parameter int NUM_COLS = 8,
   parameter int SCN_W    = 8,
   parameter int ACC_W    = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               integ,
   input  logic [NUM_ROWS*NUM_COLS*SCN_W-1:0] scene,
   input  logic [NUM_ROWS-1:0]                word_ln,
   input  logic [NUM_COLS-1:0]                bit_ln,
   input  logic [NUM_ROWS-1:0]                rsel,
   input  logic                               xfer_ln,
   input  logic                               rst_ln,
   output logic [NUM_COLS*ACC_W-1:0]          col_level
);
   localparam int NPIX = NUM_ROWS * NUM_COLS;

   logic [NPIX*ACC_W-1:0] acc_flat;
   logic [NPIX-1:0]       mem_flat;

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      for (genvar c = 0; c < NUM_COLS; c++) begin : g_pix
         localparam int IDX = r * NUM_COLS + c;
         logic             mem_q;
         logic [ACC_W-1:0] acc_q, acc_nxt;
         logic [ACC_W:0]   sum;

         assign sum = {1'b0, acc_q} + (ACC_W+1)'(scene[IDX*SCN_W +: SCN_W]);

         if (SATURATE) begin : g_sat
            assign acc_nxt = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
         end else begin : g_wrap
            assign acc_nxt = sum[ACC_W-1:0];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem_q <= 1'b0;
               acc_q <= '0;
            end else begin
               if (word_ln[r]) mem_q <= bit_ln[c];
               if (rst_ln && rsel[r] && mem_q) acc_q <= '0;
               else if (integ)                 acc_q <= acc_nxt;
            end
         end

         assign acc_flat[IDX*ACC_W +: ACC_W] = acc_q;
         assign mem_flat[IDX] = mem_q;
      end
   end

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_colout
      logic [ACC_W-1:0] pick, lvl_q;

      always_comb begin
         pick = '0;
         for (int r = 0; r < NUM_ROWS; r++)
            if (rsel[r] && mem_flat[r*NUM_COLS + c])
               pick = pick | acc_flat[(r*NUM_COLS + c)*ACC_W +: ACC_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       lvl_q <= '0;
         else if (xfer_ln) lvl_q <= pick;
      end

      assign col_level[c*ACC_W +: ACC_W] = lvl_q;
   end
endmodule

// File: rtl/cexp_row_sequencer.sv
module cexp_row_sequencer
   import cexp_pkg::*;
#(
   parameter int NUM_ROWS = 4,
   parameter int NUM_COLS = 8,
   parameter int CNT_W    = 4,
   parameter int SCN_W    = 8,
   parameter int ACC_W    = 10,
   parameter bit SATURATE = 1'b1,
   localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               frame_start,
   input  logic [CNT_W-1:0]                   t_write,
   input  logic [CNT_W-1:0]                   t_select,
   input  logic [CNT_W-1:0]                   t_xfer,
   input  logic [CNT_W-1:0]                   t_conv,
   input  logic [CNT_W-1:0]                   t_reset,
   output logic                               row_req,
   output logic [ROW_W-1:0]                   row_idx,
   input  logic [NUM_COLS-1:0]                exp_vec,
   input  logic [NUM_COLS-1:0]                en_vec,
   input  logic [NUM_ROWS*NUM_COLS*SCN_W-1:0] scene,
   output logic [NUM_ROWS-1:0]                word_ln,
   output logic [NUM_COLS-1:0]                bit_ln,
   output logic [NUM_COLS-1:0]                bit_n,
   output logic [NUM_ROWS-1:0]                rsel,
   output logic                               xfer_ln,
   output logic                               rst_ln,
   output logic [NUM_COLS-1:0]                conv_en,
   output logic                               rd_valid,
   output logic [ROW_W-1:0]                   rd_row,
   output logic [NUM_COLS*ACC_W-1:0]          rd_data
);
   if (NUM_ROWS < 1 || NUM_COLS < 1) begin : g_bad_dims
      $error("array dimensions must be positive");
   end
   if (ACC_W < SCN_W) begin : g_bad_acc
      $error("accumulator narrower than scene value");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("step counter needs at least two bits");
   end

   seq_state_t                state;
   logic [ROW_W-1:0]          row;
   logic                      step_last, integ;
   logic                      in_row, in_write, in_conv, conv_done;
   logic [NUM_COLS*ACC_W-1:0] col_level;

   cexp_row_fsm #(
      .NUM_ROWS (NUM_ROWS),
      .CNT_W    (CNT_W),
      .ROW_W    (ROW_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .t_write     (t_write),
      .t_select    (t_select),
      .t_xfer      (t_xfer),
      .t_conv      (t_conv),
      .t_reset     (t_reset),
      .state_o     (state),
      .row_o       (row),
      .step_last   (step_last),
      .integ       (integ)
   );

   assign in_row    = (state == ST_SELECT) || (state == ST_XFER) ||
                      (state == ST_CONV)   || (state == ST_RESET);
   assign in_write  = (state == ST_WRITE);
   assign in_conv   = (state == ST_CONV);
   assign conv_done = in_conv && step_last;
   assign xfer_ln   = (state == ST_XFER);
   assign rst_ln    = (state == ST_RESET);
   assign row_req   = (state == ST_LOAD);
   assign row_idx   = row;

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rowdec
      assign rsel[r]    = in_row && (row == ROW_W'(r));
      assign word_ln[r] = in_write && step_last && (row == ROW_W'(r));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rd_row <= '0;
      else if (conv_done) rd_row <= row;
   end

   cexp_col_bank #(
      .NUM_COLS (NUM_COLS),
      .ACC_W    (ACC_W)
   ) u_cols (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (row_req),
      .exp_vec   (exp_vec),
      .en_vec    (en_vec),
      .in_write  (in_write),
      .in_conv   (in_conv),
      .conv_done (conv_done),
      .col_level (col_level),
      .bit_ln    (bit_ln),
      .bit_n     (bit_n),
      .conv_en   (conv_en),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   cexp_pixel_model #(
      .NUM_ROWS (NUM_ROWS),
      .NUM_COLS (NUM_COLS),
      .SCN_W    (SCN_W),
      .ACC_W    (ACC_W),
      .SATURATE (SATURATE)
   ) u_pix (
      .clk       (clk),
      .rst_n     (rst_n),
      .integ     (integ),
      .scene     (scene),
      .word_ln   (word_ln),
      .bit_ln    (bit_ln),
      .rsel      (rsel),
      .xfer_ln   (xfer_ln),
      .rst_ln    (rst_ln),
      .col_level (col_level)
   );
endmodule

// File: rtl/cexp_row_sequencer_chk.sv
module cexp_row_sequencer_chk #(
   parameter int NUM_ROWS = 4,
   parameter int NUM_COLS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                row_req,
   input logic [NUM_ROWS-1:0] word_ln,
   input logic [NUM_COLS-1:0] bit_ln,
   input logic [NUM_COLS-1:0] bit_n,
   input logic [NUM_ROWS-1:0] rsel,
   input logic                xfer_ln,
   input logic                rst_ln,
   input logic [NUM_COLS-1:0] conv_en,
   input logic                rd_valid
);
   // R2
   row_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_req |=> !row_req);

   // R4
   word_bits_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|word_ln) |-> ($stable(bit_ln) && $stable(bit_n) && (bit_ln == ~bit_n)));

   // R4
   word_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|word_ln) |-> ($countones(word_ln) == 1 && rsel == '0 && !xfer_ln && !rst_ln));

   // R5
   rsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsel));

   // R5
   xfer_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ln |-> ($countones(rsel) == 1 && !rst_ln));

   // R6
   conv_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|conv_en) |-> ($countones(rsel) == 1 && !xfer_ln && !rst_ln));

   // R7
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R7
   rd_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(|conv_en));

   // R8
   rst_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ln |-> ($countones(rsel) == 1));
endmodule

bind cexp_row_sequencer cexp_row_sequencer_chk #(
   .NUM_ROWS (NUM_ROWS),
   .NUM_COLS (NUM_COLS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .row_req  (row_req),
   .word_ln  (word_ln),
   .bit_ln   (bit_ln),
   .bit_n    (bit_n),
   .rsel     (rsel),
   .xfer_ln  (xfer_ln),
   .rst_ln   (rst_ln),
   .conv_en  (conv_en),
   .rd_valid (rd_valid)
);

// File: tb/cexp_row_sequencer_tb.sv
module cexp_row_sequencer_tb;
   localparam int NR   = 4;
   localparam int NC   = 8;
   localparam int CW   = 4;
   localparam int SW   = 8;
   localparam int AW   = 10;
   localparam int RW   = 2;
   localparam int AMAX = (1 << AW) - 1;

   typedef struct {
      logic [RW-1:0]    row;
      logic [NC*AW-1:0] data;
   } rd_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0;
   logic [CW-1:0] t_write = '0, t_select = '0, t_xfer = '0, t_conv = '0, t_reset = '0;
   logic row_req;
   logic [RW-1:0] row_idx;
   logic [NC-1:0] exp_vec, en_vec;
   logic [NR*NC*SW-1:0] scene = '0;
   logic [NR-1:0] word_ln, rsel;
   logic [NC-1:0] bit_ln, bit_n, conv_en;
   logic xfer_ln, rst_ln, rd_valid;
   logic [RW-1:0] rd_row;
   logic [NC*AW-1:0] rd_data;

   logic [NC-1:0] exp_tab [NR];
   logic [NC-1:0] en_tab  [NR];
   int ref_acc [NR][NC];
   int scn [NR][NC];
   rd_item_t sb_q [$];

   int total = 0, bad = 0;
   int cyc = 0, last_req = 0, req_cnt = 0, exp_period = 0;
   bit done = 1'b0;
   int seed = 7;

   always #5 clk = ~clk;

   assign exp_vec = exp_tab[row_idx];
   assign en_vec  = en_tab[row_idx];

   cexp_row_sequencer #(
      .NUM_ROWS(NR), .NUM_COLS(NC), .CNT_W(CW), .SCN_W(SW), .ACC_W(AW), .SATURATE(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .t_write(t_write), .t_select(t_select), .t_xfer(t_xfer), .t_conv(t_conv), .t_reset(t_reset),
      .row_req(row_req), .row_idx(row_idx), .exp_vec(exp_vec), .en_vec(en_vec), .scene(scene),
      .word_ln(word_ln), .bit_ln(bit_ln), .bit_n(bit_n), .rsel(rsel),
      .xfer_ln(xfer_ln), .rst_ln(rst_ln), .conv_en(conv_en),
      .rd_valid(rd_valid), .rd_row(rd_row), .rd_data(rd_data)
   );

   task automatic check(input bit ok, input string tag, input string act, input string expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%s expected=%s", tag, act, expv);
      end
   endtask

   function automatic int rnd();
      seed = seed * 1103515245 + 12345;
      return (seed >>> 8) & 32'h7fff;
   endfunction

   function automatic int floor_of(input int t, input int f);
      return (t < f) ? f : t;
   endfunction

   // Monitor: samples on the falling edge, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cyc++;
         if (row_req) begin
            // R2 ascending order
            check(row_idx == RW'(req_cnt), "R2 row order",
                  $sformatf("%0d", row_idx), $sformatf("%0d", req_cnt));
            // R3 row period
            if (req_cnt > 0)
               check(cyc - last_req == exp_period, "R3 row period",
                     $sformatf("%0d", cyc - last_req), $sformatf("%0d", exp_period));
            last_req = cyc;
            req_cnt++;
         end
         if (|word_ln) begin
            // R4 word line and bit lines
            check(word_ln == (NR'(1) << row_idx) && bit_ln == exp_tab[row_idx] &&
                  bit_n == ~exp_tab[row_idx], "R4 write",
                  $sformatf("w=%b b=%b n=%b", word_ln, bit_ln, bit_n),
                  $sformatf("w=%b b=%b n=%b", NR'(1) << row_idx, exp_tab[row_idx], ~exp_tab[row_idx]));
         end
         if (xfer_ln) begin
            // R5 transfer on the selected row
            check(rsel == (NR'(1) << row_idx), "R5 select",
                  $sformatf("%b", rsel), $sformatf("%b", NR'(1) << row_idx));
         end
         if (rst_ln) begin
            // R8 reset on the selected row
            check(rsel == (NR'(1) << row_idx), "R8 reset row",
                  $sformatf("%b", rsel), $sformatf("%b", NR'(1) << row_idx));
         end
         if (|conv_en) begin
            // R6 conversion enables
            check(conv_en == (exp_tab[row_idx] & en_tab[row_idx]), "R6 conv_en",
                  $sformatf("%b", conv_en), $sformatf("%b", exp_tab[row_idx] & en_tab[row_idx]));
         end
         if (rd_valid) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R7 unexpected readout", $sformatf("row %0d", rd_row), "none");
            end else begin
               rd_item_t it;
               it = sb_q.pop_front();
               // R7 row tag, R11 coded sums (R9 zero fields)
               check(rd_row == it.row, "R7 rd_row",
                     $sformatf("%0d", rd_row), $sformatf("%0d", it.row));
               check(rd_data == it.data, "R11 coded value",
                     $sformatf("%h", rd_data), $sformatf("%h", it.data));
            end
         end
      end
   end

   // Driver: builds the reference, pushes expected readouts, runs one frame.
   task automatic run_frame(input int tw, input int ts, input int tx, input int tc,
                            input int tr, input bit extra_start);
      int per, wait_n;
      for (int r = 0; r < NR; r++)
         for (int c = 0; c < NC; c++) begin
            scene[(r*NC + c)*SW +: SW] = SW'(scn[r][c]);
            ref_acc[r][c] = ref_acc[r][c] + scn[r][c];
            if (ref_acc[r][c] > AMAX) ref_acc[r][c] = AMAX;
         end
      for (int r = 0; r < NR; r++) begin
         rd_item_t it;
         it.row  = RW'(r);
         it.data = '0;
         for (int c = 0; c < NC; c++)
            if (exp_tab[r][c] && en_tab[r][c])
               it.data[c*AW +: AW] = AW'(ref_acc[r][c]);
         if ((exp_tab[r] & en_tab[r]) != '0) sb_q.push_back(it);
         for (int c = 0; c < NC; c++)
            if (exp_tab[r][c]) ref_acc[r][c] = 0;
      end
      per = 1 + floor_of(tw, 2) + floor_of(ts, 1) + floor_of(tx, 1) +
            floor_of(tc, 1) + floor_of(tr, 1);
      t_write = CW'(tw); t_select = CW'(ts); t_xfer = CW'(tx);
      t_conv = CW'(tc);  t_reset = CW'(tr);
      @(negedge clk);
      exp_period = per;
      req_cnt = 0;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      wait_n = NR * per + 6;
      if (extra_start) begin
         repeat (5) @(negedge clk);
         // R2 a pulse mid-scan must be ignored
         frame_start = 1'b1;
         t_write = '1; t_conv = '1;
         @(negedge clk);
         frame_start = 1'b0;
         wait_n = wait_n - 6;
      end
      repeat (wait_n) @(negedge clk);
      check(req_cnt == NR, "R2 rows per frame",
            $sformatf("%0d", req_cnt), $sformatf("%0d", NR));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < NR; r++) begin
         exp_tab[r] = '0;
         en_tab[r]  = '0;
         for (int c = 0; c < NC; c++) begin
            ref_acc[r][c] = 0;
            scn[r][c] = 0;
         end
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check(word_ln == '0 && bit_ln == '0 && bit_n == '0 && rsel == '0 && !xfer_ln &&
            !rst_ln && conv_en == '0 && !row_req && !rd_valid && rd_data == '0,
            "R1 reset state", $sformatf("rv=%b rq=%b rs=%b", rd_valid, row_req, rsel), "all low");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Start all exposures: every pixel reset, nothing converted (R8).
      for (int r = 0; r < NR; r++) begin
         exp_tab[r] = '1;
         en_tab[r]  = '0;
         for (int c = 0; c < NC; c++) scn[r][c] = rnd() % 64;
      end
      run_frame(2, 1, 1, 1, 1, 1'b0);

      // Random coded frames with varying step lengths, zero floors (R3),
      // isolated pixels carrying sums across frames (R9, R11).
      for (int f = 0; f < 8; f++) begin
         for (int r = 0; r < NR; r++) begin
            exp_tab[r] = NC'(rnd());
            en_tab[r]  = NC'(rnd()) | NC'(rnd());
            for (int c = 0; c < NC; c++) scn[r][c] = rnd() % 64;
         end
         run_frame(f % 4, f % 3, 1 + f % 2, f % 5, f % 3, f == 3);
      end

      // Read and clear everything (R11).
      for (int r = 0; r < NR; r++) begin
         exp_tab[r] = '1;
         en_tab[r]  = '1;
         for (int c = 0; c < NC; c++) scn[r][c] = rnd() % 64;
      end
      run_frame(3, 2, 2, 2, 2, 1'b0);

      // Saturation: isolated pixels fed full-scale values (R10).
      for (int f = 0; f < 5; f++) begin
         for (int r = 0; r < NR; r++) begin
            exp_tab[r] = '0;
            en_tab[r]  = '1;
            for (int c = 0; c < NC; c++) scn[r][c] = 255;
         end
         run_frame(2, 1, 1, 1, 1, 1'b0);
      end
      for (int r = 0; r < NR; r++) begin
         exp_tab[r] = '1;
         en_tab[r]  = 8'h5A;
         for (int c = 0; c < NC; c++) scn[r][c] = 0;
      end
      run_frame(2, 1, 1, 1, 1, 1'b0);
      // R10: clamp value reached before readout
      check(ref_acc[0][1] == 0 && sb_q.size() == 0, "R10 saturation readout drained",
            $sformatf("%0d", sb_q.size()), "0");

      // R7 every expected readout arrived
      check(sb_q.size() == 0, "R7 scoreboard empty",
            $sformatf("%0d", sb_q.size()), "0");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule